// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is meant for significand products inside a floating-point datapath, where the whole product is passed on without rounding. The structure is the regular carry-save array. Every partial-product bit is the AND of one bit of each operand. A first row of half adders starts the reduction, and N-2 rows of full adders continue it. Each row has N-1 adders, and each row hands its carries diagonally down to the next row instead of rippling them sideways. A final ripple-carry row merges the last sum and carry vectors.

The low N product bits come out of the right-hand column of each reduction row. The high N bits come out of the merge row. By default the block is purely combinational. Setting `MID_REG` places one register row after reduction row N/2. That row captures the sum and carry vectors of that row, the low product bits already resolved, and the operand bits still needed by the lower half of the array. The result then appears exactly one clock after the operands. A new operand pair can be applied every cycle.

Top module: `csa_array_mult`

## Requirements
- R1: The output `p` equals the unsigned product of `a` and `b` over all 2N bits, for every operand pair.
- R2: When either operand is zero, every bit of `p` is zero.
- R3: When `b` is 1, `p` equals `a` zero-extended to 2N bits.
- R4: With both operands all ones, `p` equals (2^N-1)^2. For N=24 this is 0xFFFFFE000001; for N=4 it is 225.
- R5: For operands 2^i and 2^j (single bits i, j in 0..N-1), exactly bit i+j of `p` is set.
- R6: With `MID_REG` = 0, `p` follows the operands with no clock edge in between.
- R7: With `MID_REG` = 1, `p` shows the product of the operands sampled at the previous rising edge of `clk`. It is unaffected by operand changes made since that edge, and a new operand pair is accepted every cycle.
- R8: With `MID_REG` = 1, while `rst_n` is low the register row is cleared and `p` reads zero, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional mid-array register row |
| rst_n | input | 1 | Active-low asynchronous reset of the register row |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| p | output | 2N | Full unsigned product |

## Verification
The bench builds three copies of the block. The first is the default 24-bit combinational array, exercised with zero, identity, all-ones, every single-bit pair and a few thousand random pairs. The other two are 4-bit arrays, one combinational and one with the register row. At N=4 all 256 operand pairs are swept exhaustively in both modes, which exercises every diagonal carry path and every merge-row carry. In the registered copy the sweep is streamed back to back, which exposes the one-cycle latency, the holding of the output against fresh operands, and the cleared output during reset.

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int N       = 24,
  parameter bit MID_REG = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int W   = N - 1;
  localparam int MID = N / 2;

  logic [W-1:0]   s [1:N-1];
  logic [W-1:0]   c [1:N-1];
  logic [W-1:0]   s_q, c_q;
  logic [MID-1:0] lo_d, lo_q;
  logic [N-1:0]   a_r;
  logic [N-1:MID] b_r;
  logic [W:1]     rc;

  // first row: half adders
  for (genvar i = 0; i < W; i++) begin : g_row1
    logic x, y;
    assign x        = a[i+1] & b[0];
    assign y        = a[i]   & b[1];
    assign s[1][i]  = x ^ y;
    assign c[1][i]  = x & y;
  end

  // middle rows: full adders, carries enter the next row one column down
  for (genvar j = 2; j < N; j++) begin : g_row
    logic [N-1:0] aj;
    logic         bj, bjm1;
    logic [W-1:0] sp, cp;

    if (j > MID) begin : g_late
      assign aj   = a_r;
      assign bj   = b_r[j];
      assign bjm1 = b_r[j-1];
    end else begin : g_early
      assign aj   = a;
      assign bj   = b[j];
      assign bjm1 = b[j-1];
    end

    if (j == MID + 1) begin : g_cut
      assign sp = s_q;
      assign cp = c_q;
    end else begin : g_pass
      assign sp = s[j-1];
      assign cp = c[j-1];
    end

    for (genvar i = 0; i < W; i++) begin : g_fa
      logic x, y, z;
      assign x = aj[i] & bj;
      if (i == W - 1) begin : g_top
        assign y = aj[N-1] & bjm1;
      end else begin : g_in
        assign y = sp[i+1];
      end
      assign z       = cp[i];
      assign s[j][i] = x ^ y ^ z;
      assign c[j][i] = (x & y) | (x & z) | (y & z);
    end
  end

  // low product bits
  for (genvar j = 0; j < MID; j++) begin : g_lo
    if (j == 0) begin : g_b0
      assign lo_d[j] = a[0] & b[0];
    end else begin : g_bj
      assign lo_d[j] = s[j][0];
    end
  end

  // optional register row after row MID
  if (MID_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q  <= '0;
        c_q  <= '0;
        lo_q <= '0;
        a_r  <= '0;
        b_r  <= '0;
      end else begin
        s_q  <= s[MID];
        c_q  <= c[MID];
        lo_q <= lo_d;
        a_r  <= a;
        b_r  <= b[N-1:MID];
      end
    end
  end else begin : g_comb
    assign s_q  = s[MID];
    assign c_q  = c[MID];
    assign lo_q = lo_d;
    assign a_r  = a;
    assign b_r  = b[N-1:MID];
  end

  assign p[MID-1:0] = lo_q;
  assign p[MID]     = s_q[0];
  for (genvar j = MID + 1; j < N; j++) begin : g_mid_out
    assign p[j] = s[j][0];
  end

  // merge row: ripple carry over the last sum/carry vectors
  for (genvar i = 0; i < W; i++) begin : g_merge
    logic x, y;
    assign x = c[N-1][i];
    if (i == W - 1) begin : g_top
      assign y = a_r[N-1] & b_r[N-1];
    end else begin : g_in
      assign y = s[N-1][i+1];
    end
    if (i == 0) begin : g_ha
      assign p[N]  = x ^ y;
      assign rc[1] = x & y;
    end else begin : g_fa
      assign p[N+i]  = x ^ y ^ rc[i];
      assign rc[i+1] = (x & y) | (x & rc[i]) | (y & rc[i]);
    end
  end
  assign p[2*N-1] = rc[W];

  // checks
  if (!MID_REG) begin : g_chk_comb
    AST_PRODUCT_COMB: assert property (@(posedge clk) disable iff (!rst_n)
      p == ({{N{1'b0}}, a} * {{N{1'b0}}, b})); // R1
    AST_ZERO_COMB: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 || b == '0) |-> p == '0); // R2
    AST_IDENT_COMB: assert property (@(posedge clk) disable iff (!rst_n)
      (b == N'(1)) |-> p == {{N{1'b0}}, a}); // R3
  end else begin : g_chk_pipe
    AST_PRODUCT_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> p == ({{N{1'b0}}, $past(a)} * {{N{1'b0}}, $past(b)})); // R7
    AST_ZERO_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 || b == '0) |=> p == '0); // R2
    AST_IDENT_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (b == N'(1)) |=> p == {{N{1'b0}}, $past(a)}); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> p == '0); // R8
  end
endmodule

// File: tb/csa_array_mult_tb.sv
module csa_array_mult_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [23:0] a24 = '0, b24 = '0;
  logic [47:0] p24;
  logic [3:0]  a4c = '0, b4c = '0, a4r = '0, b4r = '0;
  logic [7:0]  p4c, p4r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  csa_array_mult #(.N(24), .MID_REG(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .a(a24), .b(b24), .p(p24));
  csa_array_mult #(.N(4), .MID_REG(1'b0)) dut_n4c_i (
    .clk(clk), .rst_n(rst_n), .a(a4c), .b(b4c), .p(p4c));
  csa_array_mult #(.N(4), .MID_REG(1'b1)) dut_n4r_i (
    .clk(clk), .rst_n(rst_n), .a(a4r), .b(b4r), .p(p4r));

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run24(input string req, input logic [23:0] x, input logic [23:0] y);
    longint unsigned e;
    a24 = x; b24 = y;
    #1;
    e = longint'(x) * longint'(y);
    check(req, p24, e);
  endtask

  initial begin
    // R8: register row held clear during reset, operands nonzero
    @(negedge clk);
    a4r = 4'hF; b4r = 4'hF;
    @(negedge clk);
    check("R8 reset output", p4r, 0);
    a4r = 4'h0; b4r = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release with zero operands", p4r, 0);

    // R1 R6: exhaustive 4-bit combinational sweep, no clock edge needed
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        a4c = 4'(x); b4c = 4'(y);
        #1;
        check("R1 R6 n4 comb", p4c, longint'(x * y));
      end
    end
    a4c = 4'hF; b4c = 4'hF; #1;
    check("R4 n4 all ones", p4c, 225);

    // R2: zero operand
    run24("R2 a zero", 24'h0, 24'hABCDEF);
    run24("R2 b zero", 24'hFFFFFF, 24'h0);
    run24("R2 both zero", 24'h0, 24'h0);
    // R3: identity
    run24("R3 identity", 24'h123456, 24'h1);
    run24("R3 identity ones", 24'hFFFFFF, 24'h1);
    // R4: all ones
    a24 = 24'hFFFFFF; b24 = 24'hFFFFFF; #1;
    check("R4 n24 all ones", p24, 64'hFFFFFE000001);
    // R5: single-bit operands
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 24; j++) begin
        a24 = 24'(1) << i; b24 = 24'(1) << j; #1;
        check("R5 single bits", p24, longint'(1) << (i + j));
      end
    end
    // R1: random pairs
    for (int k = 0; k < 3000; k++) begin
      run24("R1 random", 24'($urandom), 24'($urandom));
    end

    // R7: registered copy, result waits for a clock edge
    @(negedge clk);
    a4r = 4'd3; b4r = 4'd5;
    #1;
    check("R7 held before edge", p4r, 0);
    @(negedge clk);
    check("R7 one cycle later", p4r, 15);
    a4r = 4'd9; b4r = 4'd7;
    #1;
    check("R7 new operands not yet visible", p4r, 15);
    @(negedge clk);
    check("R7 next result", p4r, 63);
    // R7 R1: exhaustive back-to-back stream
    for (int k = 0; k <= 256; k++) begin
      if (k > 0) check("R7 R1 n4 pipelined", p4r, longint'(((k - 1) / 16) * ((k - 1) % 16)));
      if (k < 256) begin
        a4r = 4'(k / 16); b4r = 4'(k % 16);
      end
      @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule